// File: doc/BRIEF.md
# Effective Address and Operand Fetch Unit

This unit sits between an instruction decoder and the execution stage. For each request it takes an addressing mode code, two address or constant fields, the index register, one selected general register and the program counter. It forms the effective address and, when the mode calls for it, reads the operand through a single synchronous memory read port. Depending on the mode, a request needs no memory read, one read, or two reads in a chain, where the first read supplies part of the address.

Requests enter through a valid/ready handshake. `req_ready` is high only while the unit is idle, and a request is taken on the rising edge where `req_valid` and `req_ready` are both high. All request fields are sampled on that edge. The result has no back-pressure: `res_valid` is high for exactly one cycle, and `res_ea` and `res_operand` hold their values until the next request is taken. A store-type request sets `req_ea_only`. This skips the final operand read but keeps any reads that are needed to build the address.

Top module: `ea_fetch_unit`

## Requirements
- R1: `req_ready` is high only when the unit is idle. It is low in the cycle after a request is taken. `res_valid` is high for exactly one cycle for each request taken.
- R2: Mode code 0 (inherent) makes no memory read. `res_valid` rises one cycle after the request is taken, and `res_ea` and `res_operand` are both 0.
- R3: Mode code 1 (immediate) makes no memory read. The result comes one cycle after the request is taken, with `res_operand` equal to field 1 and `res_ea` equal to 0.
- R4: Mode code 2 (direct) gives a result with `res_ea` equal to field 1. It makes one read at that address, and `res_operand` is the word read. The result comes three cycles after the request is taken.
- R5: Mode code 3 (register-indexed) gives `res_ea` equal to field 1 plus the index input, modulo 2^16. The operand is read at that address with the same timing as direct mode.
- R6: Mode code 4 (register-indirect) gives `res_ea` equal to the register input. The operand is read at that address with the same timing as direct mode.
- R7: Mode code 5 (memory-indexed) first reads the word at field 2. `res_ea` is field 1 plus that word, modulo 2^16. A second read at `res_ea` gives the operand, and the result comes five cycles after the request is taken.
- R8: Mode code 6 (memory-indirect) first reads the word at field 1, and that word becomes `res_ea`. A second read at `res_ea` gives the operand, with the same timing as R7.
- R9: Mode code 7 (relative) gives `res_ea` equal to the program counter plus field 1, where field 1 is a signed two's-complement offset and the sum wraps modulo 2^16. It makes no memory read. `res_operand` is 0 and the result comes one cycle after the request is taken.
- R10: With `req_ea_only` set, no operand read is made and `res_operand` is 0. For modes 2 to 4 there are no reads and the result comes after one cycle. For modes 5 and 6 only the address-forming read is made and the result comes after three cycles.
- R11: `mem_rd_en` is never high in two cycles in a row. Read data is taken from `mem_rd_data` one cycle after the matching `mem_rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle and able to take a request |
| req_mode | input | 3 | Addressing mode code |
| req_field1 | input | 16 | Address, constant, base or offset field |
| req_field2 | input | 16 | Second address field (memory-indexed subscript location) |
| req_index | input | 16 | Index register value |
| req_reg | input | 16 | Selected general register value |
| req_pc | input | 16 | Current program counter |
| req_ea_only | input | 1 | Skip the final operand read |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_addr | output | 16 | Memory read address |
| mem_rd_data | input | 16 | Read data, one cycle after the strobe |
| res_valid | output | 1 | One-cycle result pulse |
| res_ea | output | 16 | Effective address |
| res_operand | output | 16 | Fetched or immediate operand |

## Verification
The assertions check on every cycle that the result pulse lasts one cycle, that `req_ready` drops after a request is taken, and that reads are never issued back to back. They also check the results of the modes that need no read: inherent, immediate and relative, including their one-cycle latency and the absence of any read. The correctness of the chained address, the read addresses, the operand values and the latencies of the read modes depends on memory contents. Only the bench's sweep over modes, the ea-only flag and wrapping field values can show these, by checking against a memory model whose contents are computed.

// File: rtl/ea_pkg.sv
package ea_pkg;
  typedef enum logic [2:0] {
    MODE_INHERENT = 3'd0,
    MODE_IMMED    = 3'd1,
    MODE_DIRECT   = 3'd2,
    MODE_REG_IDX  = 3'd3,
    MODE_REG_IND  = 3'd4,
    MODE_MEM_IDX  = 3'd5,
    MODE_MEM_IND  = 3'd6,
    MODE_RELATIVE = 3'd7
  } ea_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PTR_RD,
    ST_PTR_WAIT,
    ST_OP_RD,
    ST_OP_WAIT,
    ST_FIN
  } ea_state_e;
endpackage

// File: rtl/ea_addr_calc.sv
module ea_addr_calc
  import ea_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [2:0]   mode,
  input  logic         ea_only,
  input  logic [W-1:0] field1,
  input  logic [W-1:0] field2,
  input  logic [W-1:0] index_val,
  input  logic [W-1:0] reg_val,
  input  logic [W-1:0] pc_val,
  output logic [W-1:0] first_addr,
  output logic [W-1:0] chain_base,
  output logic [W-1:0] imm_operand,
  output logic         needs_ptr,
  output logic         needs_op
);
  ea_mode_e m;
  assign m = ea_mode_e'(mode);

  always_comb begin
    first_addr  = '0;
    chain_base  = '0;
    imm_operand = '0;
    needs_ptr   = 1'b0;
    needs_op    = 1'b0;
    unique case (m)
      MODE_INHERENT: ;
      MODE_IMMED:    imm_operand = field1;
      MODE_DIRECT: begin
        first_addr = field1;
        needs_op   = !ea_only;
      end
      MODE_REG_IDX: begin
        first_addr = field1 + index_val;
        needs_op   = !ea_only;
      end
      MODE_REG_IND: begin
        first_addr = reg_val;
        needs_op   = !ea_only;
      end
      MODE_MEM_IDX: begin
        first_addr = field2;
        chain_base = field1;
        needs_ptr  = 1'b1;
        needs_op   = !ea_only;
      end
      MODE_MEM_IND: begin
        first_addr = field1;
        needs_ptr  = 1'b1;
        needs_op   = !ea_only;
      end
      MODE_RELATIVE: first_addr = pc_val + field1;
      default: ;
    endcase
  end
endmodule

// File: rtl/ea_ctrl.sv
module ea_ctrl
  import ea_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  output logic         req_ready,
  input  logic [W-1:0] first_addr,
  input  logic [W-1:0] chain_base,
  input  logic [W-1:0] imm_operand,
  input  logic         needs_ptr,
  input  logic         needs_op,
  output logic         mem_rd_en,
  output logic [W-1:0] mem_addr,
  input  logic [W-1:0] mem_rd_data,
  output logic         res_valid,
  output logic [W-1:0] res_ea,
  output logic [W-1:0] res_operand
);
  ea_state_e    state;
  logic [W-1:0] addr_q;
  logic [W-1:0] base_q;
  logic [W-1:0] opnd_q;
  logic         op_q;
  logic         accept;

  assign req_ready   = (state == ST_IDLE);
  assign accept      = req_valid && req_ready;
  assign mem_rd_en   = (state == ST_PTR_RD) || (state == ST_OP_RD);
  assign mem_addr    = addr_q;
  assign res_valid   = (state == ST_FIN);
  assign res_ea      = addr_q;
  assign res_operand = opnd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      addr_q <= '0;
      base_q <= '0;
      opnd_q <= '0;
      op_q   <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) begin
          addr_q <= first_addr;
          base_q <= chain_base;
          opnd_q <= imm_operand;
          op_q   <= needs_op;
          if (needs_ptr)     state <= ST_PTR_RD;
          else if (needs_op) state <= ST_OP_RD;
          else               state <= ST_FIN;
        end
        ST_PTR_RD:   state <= ST_PTR_WAIT;
        ST_PTR_WAIT: begin
          addr_q <= base_q + mem_rd_data;
          state  <= op_q ? ST_OP_RD : ST_FIN;
        end
        ST_OP_RD:    state <= ST_OP_WAIT;
        ST_OP_WAIT: begin
          opnd_q <= mem_rd_data;
          state  <= ST_FIN;
        end
        ST_FIN:      state <= ST_IDLE;
        default:     state <= ST_IDLE;
      endcase
    end
  end

  assert_done_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
  assert_busy_after_take_R1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);
  assert_no_back_to_back_rd_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en);
endmodule

// File: rtl/ea_fetch_unit.sv
module ea_fetch_unit
  import ea_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  output logic         req_ready,
  input  logic [2:0]   req_mode,
  input  logic [W-1:0] req_field1,
  input  logic [W-1:0] req_field2,
  input  logic [W-1:0] req_index,
  input  logic [W-1:0] req_reg,
  input  logic [W-1:0] req_pc,
  input  logic         req_ea_only,
  output logic         mem_rd_en,
  output logic [W-1:0] mem_addr,
  input  logic [W-1:0] mem_rd_data,
  output logic         res_valid,
  output logic [W-1:0] res_ea,
  output logic [W-1:0] res_operand
);
  logic [W-1:0] first_addr, chain_base, imm_operand;
  logic         needs_ptr, needs_op;

  ea_addr_calc #(.W(W)) calc_i (
    .mode(req_mode), .ea_only(req_ea_only),
    .field1(req_field1), .field2(req_field2),
    .index_val(req_index), .reg_val(req_reg), .pc_val(req_pc),
    .first_addr(first_addr), .chain_base(chain_base),
    .imm_operand(imm_operand), .needs_ptr(needs_ptr), .needs_op(needs_op)
  );

  ea_ctrl #(.W(W)) ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .first_addr(first_addr), .chain_base(chain_base),
    .imm_operand(imm_operand), .needs_ptr(needs_ptr), .needs_op(needs_op),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rd_data(mem_rd_data),
    .res_valid(res_valid), .res_ea(res_ea), .res_operand(res_operand)
  );

  logic take;
  assign take = req_valid && req_ready;

  assert_inherent_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (take && req_mode == 3'd0) |=> (res_valid && res_ea == '0 && res_operand == '0 && !mem_rd_en));
  assert_immediate_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && req_mode == 3'd1) |=> (res_valid && res_operand == $past(req_field1) && !mem_rd_en));
  assert_relative_target_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (take && req_mode == 3'd7) |=> (res_valid && res_ea == W'($past(req_pc) + $past(req_field1)) && !mem_rd_en));
endmodule

// File: tb/ea_fetch_unit_tb_top.sv
`timescale 1ns/1ps
module ea_fetch_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_mode = '0;
  logic [15:0] req_field1 = '0, req_field2 = '0, req_index = '0, req_reg = '0, req_pc = '0;
  logic        req_ea_only = 1'b0;
  logic        mem_rd_en;
  logic [15:0] mem_addr;
  logic [15:0] mem_rd_data = '0;
  logic        res_valid;
  logic [15:0] res_ea, res_operand;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  ea_fetch_unit dut_i (.*);

  function automatic logic [15:0] memf(input logic [15:0] a);
    return (a * 16'd40503) ^ 16'h1234;
  endfunction

  always_ff @(posedge clk) if (mem_rd_en) mem_rd_data <= memf(mem_addr);

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_req(input logic [2:0] m, input logic [15:0] f1, input logic [15:0] f2,
                         input logic [15:0] ix, input logic [15:0] rg, input logic [15:0] pc,
                         input logic eo);
    logic [15:0] e_ea, e_op, e_a0;
    int e_rd, e_lat, lat, nrd;
    logic [15:0] a0;
    e_ea = 0; e_op = 0; e_rd = 0; e_lat = 1; e_a0 = 0;
    case (m)
      3'd1: e_op = f1;
      3'd2: begin e_ea = f1; e_a0 = f1; end
      3'd3: begin e_ea = f1 + ix; e_a0 = e_ea; end
      3'd4: begin e_ea = rg; e_a0 = rg; end
      3'd5: begin e_ea = f1 + memf(f2); e_a0 = f2; end
      3'd6: begin e_ea = memf(f1); e_a0 = f1; end
      3'd7: e_ea = pc + f1;
      default: ;
    endcase
    if (m >= 3'd2 && m <= 3'd4 && !eo) begin e_op = memf(e_ea); e_rd = 1; e_lat = 3; end
    if (m == 3'd5 || m == 3'd6) begin
      e_rd = eo ? 1 : 2; e_lat = eo ? 3 : 5;
      if (!eo) e_op = memf(e_ea);
    end
    @(negedge clk);
    check("R1 ready when idle", req_ready, 1);
    req_valid = 1; req_mode = m; req_field1 = f1; req_field2 = f2;
    req_index = ix; req_reg = rg; req_pc = pc; req_ea_only = eo;
    @(negedge clk);
    req_valid = 0; req_field1 = ~f1; req_field2 = ~f2; req_index = ~ix; req_reg = ~rg; req_pc = ~pc;
    lat = 1; nrd = 0; a0 = 0;
    while (!res_valid && lat < 12) begin
      if (mem_rd_en) begin
        if (nrd == 0) a0 = mem_addr;
        nrd++;
      end
      @(negedge clk);
      lat++;
    end
    check($sformatf("R%0s latency mode%0d eo%0d", (eo ? "10" : "4"), m, eo), lat, e_lat);
    case (m)
      3'd0: check("R2 inherent ea", res_ea, e_ea);
      3'd1: check("R3 immediate operand", res_operand, e_op);
      3'd2: check("R4 direct ea", res_ea, e_ea);
      3'd3: check("R5 indexed ea", res_ea, e_ea);
      3'd4: check("R6 reg indirect ea", res_ea, e_ea);
      3'd5: check("R7 mem indexed ea", res_ea, e_ea);
      3'd6: check("R8 mem indirect ea", res_ea, e_ea);
      default: check("R9 relative ea", res_ea, e_ea);
    endcase
    check(eo ? "R10 operand ea_only" : "R4 operand", res_operand, e_op);
    check("R11 read count", nrd, e_rd);
    if (e_rd > 0) check("R11 first read address", a0, e_a0);
    @(negedge clk);
    check("R1 single done pulse", res_valid, 0);
  endtask

  initial begin
    logic [15:0] f1s [6];
    f1s[0] = 16'h0000; f1s[1] = 16'hFFFF; f1s[2] = 16'h8000;
    f1s[3] = 16'h1234; f1s[4] = 16'hFFF0; f1s[5] = 16'h0005;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset no done", res_valid, 0);
    check("R11 reset no read", mem_rd_en, 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 ready after reset", req_ready, 1);
    for (int m = 0; m < 8; m++)
      for (int eo = 0; eo < 2; eo++)
        for (int k = 0; k < 6; k++)
          for (int j = 0; j < 4; j++)
            run_req(3'(m), f1s[k], 16'(j * 16'h3131 + 16'hFFFE),
                    16'(j * 16'h5003 + 2), 16'(16'hA5A5 ^ (j * 16'h0101)),
                    16'(16'hFFFC - j * 16'h7FFF), eo[0]);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule